// File: doc/BRIEF.md
# Page Storage-Key Reference/Change Updater

This block follows each successful address translation. It keeps one small key per page of absolute memory and updates the key for the page that an access touches. A request gives the absolute address, the kind of access and the permission flags granted so far. The block reads that page's key, sets the reference bit, and sets the change bit when the access is a store. It then writes the key back and returns the permission flags, adjusted, with a one-cycle done strobe.

The adjustment covers one case. A load or an instruction fetch to a page whose change bit is still clear loses its write permission. A later store to that page therefore takes a new miss, and the change bit gets recorded on that store. Addresses beyond the configured memory size are left alone: their flags come back unchanged and no key is touched.

The keys sit in a local array indexed by page number. The array has a direct write port, used for setup, which wins over the updater. It also has a read port that shows any key at the block's edge.

Top module: `skey_updater`

## Requirements
- R1: After reset every key reads 0 on the key read port, and `done` is low.
- R2: An in-range request accepted at clock edge N, with no key-port write during it, raises `done` for exactly one cycle after edge N+2.
- R3: For a load (`req_kind`=0), a fetch (2) or the reserved code 3, when the page's change bit (key bit 0) is 0, `out_flags` equals `req_flags` with bit 1 (write) cleared; bits 0 (read) and 2 (execute) pass through.
- R4: For a load or fetch whose page has change bit 1, `out_flags` equals `req_flags`.
- R5: A store (`req_kind`=1) sets the change bit of its page and returns `req_flags` unchanged.
- R6: Every in-range access sets the reference bit (key bit 1). Key bits 6:3 (access key) and bit 2 (fetch protect) keep their values.
- R7: The page updated is the address divided by 4096. Keys of all other pages keep their values, up to and including the last in-range page.
- R8: An address at or above `MEM_PAGES`*4096 raises `done` one cycle after edge N+1, returns `req_flags` unchanged, and changes no key.
- R9: A key-port write (`kw_en`, `kw_page`, `kw_key`) shows on the read port from the next cycle on.
- R10: Each cycle in which `kw_en` is high while an in-range update is reading or writing delays `done` by one cycle.
- R11: A key-port write to the page being updated, during the write-back cycle, is kept. The update is then applied on top of the written key, and the flags are computed from that key.
- R12: `req_valid` is ignored while an update is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Absolute address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_flags | input | 3 | Incoming permissions: bit0 read, bit1 write, bit2 execute |
| done | output | 1 | One-cycle completion strobe |
| out_flags | output | 3 | Adjusted permissions, valid with done |
| kw_en | input | 1 | Key-port write enable |
| kw_page | input | PG_W | Key-port page index |
| kw_key | input | 7 | Key value: [6:3] access key, [2] fetch protect, [1] reference, [0] change |
| kr_page | input | PG_W | Key read page index |
| kr_key | output | 7 | Key of `kr_page` |

## Verification
The assertions assume that only one request is in flight at a time, and that the requester waits for `done` before it sends the next one. They also assume that `req_kind` and `req_flags` are stable in the cycle a request is taken. The stimulus drives every request for exactly one cycle, then waits until the scoreboard has drained its expected item. It drives an extra request strobe only in the deliberate busy case. Key-port writes happen only while idle, or in one chosen cycle of an update, so that every stall adds a known number of cycles.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int KEY_W  = 7;
  localparam int FL_W   = 3;
  localparam int KB_CHG = 0;
  localparam int KB_REF = 1;
  localparam int FB_WR  = 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } upd_state_e;

  // New key: reference always, change only for stores.
  function automatic logic [KEY_W-1:0] key_next(input logic [KEY_W-1:0] k,
                                                input logic [1:0] kind);
    logic [KEY_W-1:0] r;
    r = k;
    r[KB_REF] = 1'b1;
    if (kind == ACC_STORE) r[KB_CHG] = 1'b1;
    return r;
  endfunction

  // Non-store with clean page loses write permission.
  function automatic logic [FL_W-1:0] flags_next(input logic [FL_W-1:0] f,
                                                 input logic [KEY_W-1:0] k,
                                                 input logic [1:0] kind);
    logic [FL_W-1:0] r;
    r = f;
    if (kind != ACC_STORE && !k[KB_CHG]) r[FB_WR] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/skey_addr_split.sv
module skey_addr_split #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 12,
  parameter int MEM_PAGES = 256,
  localparam int PG_W     = $clog2(MEM_PAGES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PG_W-1:0]   page,
  output logic              in_range
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_PAGES) << PAGE_BITS;

  assign page     = addr[PAGE_BITS +: PG_W];
  assign in_range = {1'b0, addr} < LIMIT;
endmodule

// File: rtl/skey_ram.sv
module skey_ram
  import skey_pkg::*;
#(
  parameter int NPAGES = 256,
  localparam int PG_W  = $clog2(NPAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kw_en,
  input  logic [PG_W-1:0]  kw_page,
  input  logic [KEY_W-1:0] kw_data,
  input  logic             upd_we,
  input  logic [PG_W-1:0]  upd_page,
  input  logic [KEY_W-1:0] upd_wdata,
  input  logic [PG_W-1:0]  rd_page_a,
  output logic [KEY_W-1:0] rd_key_a,
  input  logic [PG_W-1:0]  rd_page_b,
  output logic [KEY_W-1:0] rd_key_b
);
  logic [KEY_W-1:0] mem [NPAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGES; i++) mem[i] <= '0;
    end else if (kw_en) begin
      mem[kw_page] <= kw_data;
    end else if (upd_we) begin
      mem[upd_page] <= upd_wdata;
    end
  end

  assign rd_key_a = mem[rd_page_a];
  assign rd_key_b = mem[rd_page_b];
endmodule

// File: rtl/skey_seq.sv
module skey_seq
  import skey_pkg::*;
#(
  parameter int PG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PG_W-1:0]  req_page,
  input  logic             req_in_range,
  input  logic [1:0]       req_kind,
  input  logic [FL_W-1:0]  req_flags,
  input  logic             kw_en,
  input  logic [PG_W-1:0]  kw_page,
  input  logic [KEY_W-1:0] kw_data,
  output logic [PG_W-1:0]  rd_page,
  input  logic [KEY_W-1:0] rd_key,
  output logic             upd_we,
  output logic [PG_W-1:0]  upd_page,
  output logic [KEY_W-1:0] upd_wdata,
  output logic             accept,
  output logic             done,
  output logic [FL_W-1:0]  out_flags
);
  upd_state_e       st;
  logic [PG_W-1:0]  page_q;
  logic [1:0]       kind_q;
  logic [FL_W-1:0]  fin_q;
  logic [FL_W-1:0]  res_q;
  logic [KEY_W-1:0] key_q;
  logic             oor_q;
  logic             same_page_kw;

  assign accept       = req_valid && (st == ST_IDLE);
  assign same_page_kw = kw_en && (kw_page == page_q);
  assign rd_page      = page_q;
  assign upd_page     = page_q;
  assign upd_wdata    = key_q;
  assign upd_we       = (st == ST_WR) && !kw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      page_q    <= '0;
      kind_q    <= '0;
      fin_q     <= '0;
      res_q     <= '0;
      key_q     <= '0;
      oor_q     <= 1'b0;
      done      <= 1'b0;
      out_flags <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            page_q <= req_page;
            kind_q <= req_kind;
            fin_q  <= req_flags;
            oor_q  <= !req_in_range;
            st     <= ST_RD;
          end
        end
        ST_RD: begin
          if (oor_q) begin
            done      <= 1'b1;
            out_flags <= fin_q;
            st        <= ST_IDLE;
          end else if (!kw_en) begin
            key_q <= key_next(rd_key, kind_q);
            res_q <= flags_next(fin_q, rd_key, kind_q);
            st    <= ST_WR;
          end
        end
        ST_WR: begin
          if (kw_en) begin
            if (same_page_kw) begin
              key_q <= key_next(kw_data, kind_q);
              res_q <= flags_next(fin_q, kw_data, kind_q);
            end
          end else begin
            done      <= 1'b1;
            out_flags <= res_q;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skey_updater.sv
module skey_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 12,
  parameter int MEM_PAGES = 256,
  localparam int PG_W     = $clog2(MEM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_flags,
  output logic              done,
  output logic [2:0]        out_flags,
  input  logic              kw_en,
  input  logic [PG_W-1:0]   kw_page,
  input  logic [6:0]        kw_key,
  input  logic [PG_W-1:0]   kr_page,
  output logic [6:0]        kr_key
);
  logic [PG_W-1:0]  req_page;
  logic             req_in_range;
  logic [PG_W-1:0]  rd_page;
  logic [KEY_W-1:0] rd_key;
  logic             upd_we;
  logic [PG_W-1:0]  upd_page;
  logic [KEY_W-1:0] upd_wdata;
  logic             accept;

  skey_addr_split #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MEM_PAGES(MEM_PAGES)
  ) u_split (
    .addr(req_addr), .page(req_page), .in_range(req_in_range)
  );

  skey_seq #(.PG_W(PG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_page(req_page), .req_in_range(req_in_range),
    .req_kind(req_kind), .req_flags(req_flags),
    .kw_en(kw_en), .kw_page(kw_page), .kw_data(kw_key),
    .rd_page(rd_page), .rd_key(rd_key),
    .upd_we(upd_we), .upd_page(upd_page), .upd_wdata(upd_wdata),
    .accept(accept), .done(done), .out_flags(out_flags)
  );

  skey_ram #(.NPAGES(MEM_PAGES)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .kw_en(kw_en), .kw_page(kw_page), .kw_data(kw_key),
    .upd_we(upd_we), .upd_page(upd_page), .upd_wdata(upd_wdata),
    .rd_page_a(rd_page), .rd_key_a(rd_key),
    .rd_page_b(kr_page), .rd_key_b(kr_key)
  );
endmodule

// File: rtl/skey_updater_chk.sv
module skey_updater_chk
  import skey_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic [1:0] req_kind,
  input logic [2:0] req_flags,
  input logic       done,
  input logic [2:0] out_flags,
  input logic       upd_we,
  input logic [6:0] upd_wdata
);
  logic [1:0] cap_kind;
  logic [2:0] cap_flags;
  logic       busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_kind  <= '0;
      cap_flags <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (accept) begin
        cap_kind  <= req_kind;
        cap_flags <= req_flags;
        busy_q    <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |=> done); // R2
  AST_FLAGS_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((out_flags & ~cap_flags) == 3'b000)); // R3
  AST_STORE_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_kind == ACC_STORE) |-> (out_flags == cap_flags)); // R5
  AST_STORE_SETS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && cap_kind == ACC_STORE) |-> upd_wdata[KB_CHG]); // R5
  AST_REF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> upd_wdata[KB_REF]); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_q); // R12
endmodule

bind skey_updater skey_updater_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .req_kind(req_kind),
  .req_flags(req_flags), .done(done), .out_flags(out_flags),
  .upd_we(upd_we), .upd_wdata(upd_wdata)
);

// File: tb/skey_updater_bench.sv
module skey_updater_bench;
  localparam int ADDR_W = 24;
  localparam int PB     = 12;
  localparam int NP     = 256;
  localparam int PG_W   = $clog2(NP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_kind = '0;
  logic [2:0]        req_flags = '0;
  logic              done;
  logic [2:0]        out_flags;
  logic              kw_en = 1'b0;
  logic [PG_W-1:0]   kw_page = '0;
  logic [6:0]        kw_key = '0;
  logic [PG_W-1:0]   kr_page = '0;
  logic [6:0]        kr_key;

  skey_updater u_skey_updater (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_flags(req_flags), .done(done),
    .out_flags(out_flags), .kw_en(kw_en), .kw_page(kw_page),
    .kw_key(kw_key), .kr_page(kr_page), .kr_key(kr_key)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [2:0] fl;
    int         at;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [6:0] mk[NP];
  int         cyc = 0;
  int         total = 0;
  int         bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Expected-value model written from the requirements.
  function automatic logic [2:0] model_flags(input logic [2:0] f,
                                             input logic [6:0] k,
                                             input logic [1:0] kind);
    if (kind == 2'd1) return f;
    return k[0] ? f : {f[2], 1'b0, f[0]};
  endfunction

  function automatic logic [6:0] model_key(input logic [6:0] k,
                                           input logic [1:0] kind);
    return {k[6:2], 1'b1, k[0] | (kind == 2'd1)};
  endfunction

  // Monitor: pops expected items on every done.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(out_flags == e.fl, e.tag, "flags", int'(out_flags), int'(e.fl));
        chk(cyc == e.at, e.tag, "done cycle", cyc, e.at);
      end
    end
  end

  // Driver: called at a negedge, returns one negedge later.
  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                        input logic [2:0] fl, input int extra, input string tag);
    exp_t e;
    int   pg;
    bit   inr;
    inr = (a >> PB) < NP;
    pg  = int'(a >> PB);
    e.tag = tag;
    if (inr) begin
      e.fl = model_flags(fl, mk[pg], kind);
      e.at = cyc + 3 + extra;
      mk[pg] = model_key(mk[pg], kind);
    end else begin
      e.fl = fl;
      e.at = cyc + 2 + extra;
    end
    sb.push_back(e);
    req_valid = 1'b1;
    req_addr  = a;
    req_kind  = kind;
    req_flags = fl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic key_chk(input int pg, input string req);
    kr_page = PG_W'(pg);
    #1;
    chk(kr_key == mk[pg], req, $sformatf("key page %0d", pg),
        int'(kr_key), int'(mk[pg]));
  endtask

  task automatic kw(input int pg, input logic [6:0] d);
    kw_en   = 1'b1;
    kw_page = PG_W'(pg);
    kw_key  = d;
    mk[pg]  = d;
    @(negedge clk);
    kw_en = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) mk[i] = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    key_chk(0, "R1");
    key_chk(255, "R1");
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // R3 / R6: clean page, load and fetch lose write permission
    access(24'h005010, 2'd0, 3'b111, 0, "R3 load clean"); drain();
    key_chk(5, "R6");
    access(24'h005FF8, 2'd2, 3'b111, 0, "R3 fetch clean"); drain();
    // R5: store keeps flags, sets change bit
    access(24'h005000, 2'd1, 3'b011, 0, "R5 store"); drain();
    key_chk(5, "R5");
    // R4: dirty page keeps write permission
    access(24'h005100, 2'd0, 3'b111, 0, "R4 load dirty"); drain();
    access(24'h005200, 2'd2, 3'b110, 0, "R4 fetch dirty"); drain();
    // R3: reserved kind behaves as load
    access(24'h006000, 2'd3, 3'b011, 0, "R3 reserved kind"); drain();

    // R9 / R6 / R7: preset key, store keeps access key and fetch protect
    kw(9, 7'h5C);
    key_chk(9, "R9");
    access(24'h009ABC, 2'd1, 3'b101, 0, "R2 store preset"); drain();
    key_chk(9, "R6");
    key_chk(8, "R7");
    key_chk(10, "R7");

    // R7: last in-range page
    access(24'h0FFFFF, 2'd0, 3'b111, 0, "R7 last page"); drain();
    key_chk(255, "R7");
    key_chk(254, "R7");

    // R8: out of range, no key change (page bits alias page 0)
    access(24'h100000, 2'd1, 3'b010, 0, "R8 first beyond"); drain();
    key_chk(0, "R8");
    access(24'hFFFFFF, 2'd0, 3'b111, 0, "R8 top address"); drain();
    key_chk(255, "R8");

    // R10: key-port write to another page during read phase
    access(24'h014000, 2'd0, 3'b111, 1, "R10 stall read");
    kw(21, 7'h11);
    drain();
    key_chk(20, "R10");
    key_chk(21, "R10");

    // R11: key-port write to same page during write-back
    mk[30] = 7'h31;
    access(24'h01E000, 2'd0, 3'b111, 1, "R11 merge");
    @(negedge clk);
    kw(30, 7'h31);
    mk[30] = model_key(7'h31, 2'd0);
    drain();
    key_chk(30, "R11");

    // R12: second request while busy is dropped
    access(24'h028000, 2'd0, 3'b111, 0, "R12 first");
    req_valid = 1'b1;
    req_addr  = 24'h029000;
    req_kind  = 2'd1;
    req_flags = 3'b111;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    key_chk(41, "R12");
    key_chk(40, "R12");

    summary();
    $finish;
  end
endmodule